// File: doc/BRIEF.md
# Keyed Configuration Blob Port

This block is a register-mapped slave that hands configuration data to boot firmware one entry at a time. Firmware writes a 16-bit key into a write-only selector register. Every selector write rewinds a per-entry byte cursor to zero. Firmware then reads the 64-bit data register repeatedly, and each read pulls the next bytes of the selected entry from the cursor onward. If the selected entry is writable, data-register writes store bytes at the cursor in the same way.

A data access may be 1, 2, 4 or 8 bytes wide. A wide access behaves exactly like the same number of single-byte accesses issued back to back. The earliest byte of the stream sits in the lowest byte lane, and the cursor moves past every byte transferred.

The table is built in and small. Key 0x0000 holds a fixed four-byte ASCII signature that proves the port exists. Key 0x0001 holds a four-byte revision word whose value is zero. Key 0x0002 is a writable scratch entry whose length is a parameter. Every other key is an empty entry.

Top module: `cfg_blob_port`

## Requirements
- R1: After a synchronous active-high reset, `rspValid` is low, key 0x0000 is selected with its cursor at zero, and every scratch byte is zero.
- R2: `reqReady` is always high. Every request taken while `reqValid` is high is answered by `rspValid` high on the next cycle only.
- R3: A write at window offset 8 with `reqStrb[7:2]` all zero and at least one of `reqStrb[1:0]` set is a selector write. `reqStrb[0]` loads `reqWdata[7:0]` as the key's upper byte. `reqStrb[1]` loads `reqWdata[15:8]` as the key's lower byte. Any selector write resets the cursor to zero.
- R4: A data access at offset 0 takes one of the strobes 0x01, 0x03, 0x0F or 0xFF, which give 1, 2, 4 or 8 bytes. Lane i of the data carries stream byte cursor+i, and the cursor then advances by the access width.
- R5: Key 0x0000 streams the bytes 0x43, 0x46, 0x47, 0x50 in that order. A 32-bit read from its start therefore returns 0x50474643.
- R6: Key 0x0001 streams four bytes that form the little-endian 32-bit revision value, which is 0 by default.
- R7: A read byte whose position lies at or past the end of the entry, or that belongs to an unknown key, reads as zero. The cursor never moves beyond the entry's length.
- R8: Key 0x0002 is a writable entry of `SCR_BYTES` bytes. Lane i of a data write stores into byte cursor+i when that byte lies inside the entry, and the bytes read back later in the same order.
- R9: A data write while key 0x0000, key 0x0001 or an unknown key is selected changes neither the contents nor the cursor.
- R10: The following accesses return zero and change no state:
  - any access at an offset other than 0 or 8;
  - a data access with any other strobe pattern;
  - any read at offset 8;
  - a write at offset 8 whose strobes fall outside the selector rule of R3.
- R11: The response data of every access other than a legal data read is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request accepted (always high) |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 4 | Byte offset of the access in the register window |
| reqStrb | input | 8 | Byte-lane enables relative to the 8-byte lane |
| reqWdata | input | 64 | Write data |
| rspValid | output | 1 | Response present, one cycle after the request |
| rspData | output | 64 | Read data, or zero |

## Verification
The bench builds the block with `SCR_BYTES` set to 12 and keeps the default signature and revision. With that length, a second 8-byte access to the scratch entry straddles its end. This lets the bench check partial reads and writes at the boundary, and check that the cursor is clamped at the entry length. The short four-byte entries let 8-byte reads cover both data bytes and past-the-end bytes in a single access.

// File: rtl/cfg_blob_pkg.sv
package cfg_blob_pkg;

  localparam logic [15:0] KEY_SIG = 16'h0000;
  localparam logic [15:0] KEY_REV = 16'h0001;
  localparam logic [15:0] KEY_SCR = 16'h0002;

  localparam logic [3:0] OFS_DATA = 4'h0;
  localparam logic [3:0] OFS_SEL  = 4'h8;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic       accept;
    logic       selWr;
    logic       selHiEn;
    logic       selLoEn;
    logic       rdEn;
    logic       wrEn;
    logic [3:0] nBytes;
  } ctrlStrobes_t;

endpackage

// File: rtl/cfg_blob_ctrl.sv
module cfg_blob_ctrl
  import cfg_blob_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         reqValid,
  input  logic         reqWrite,
  input  logic [3:0]   reqAddr,
  input  logic [7:0]   reqStrb,
  output logic         reqReady,
  output ctrlStrobes_t st
);

  logic [3:0] dataWidth;

  assign reqReady = 1'b1;

  always_comb begin
    unique case (reqStrb)
      8'h01:   dataWidth = 4'd1;
      8'h03:   dataWidth = 4'd2;
      8'h0F:   dataWidth = 4'd4;
      8'hFF:   dataWidth = 4'd8;
      default: dataWidth = 4'd0;
    endcase
  end

  always_comb begin
    st = '0;
    st.accept = reqValid;
    if (reqValid) begin
      if (reqAddr == OFS_DATA && dataWidth != 4'd0) begin
        st.rdEn   = ~reqWrite;
        st.wrEn   = reqWrite;
        st.nBytes = dataWidth;
      end else if (reqAddr == OFS_SEL && reqWrite &&
                   reqStrb[7:2] == 6'b0 && reqStrb[1:0] != 2'b00) begin
        st.selWr   = 1'b1;
        st.selHiEn = reqStrb[0];
        st.selLoEn = reqStrb[1];
      end
    end
  end

  // At most one kind of action per request (R10)
  a_r10_one_action: assert property (@(posedge clk) disable iff (rst)
    $onehot0({st.selWr, st.rdEn, st.wrEn}));

  // A data access carries a legal width and nothing else does (R4)
  a_r4_width_legal: assert property (@(posedge clk) disable iff (rst)
    (st.rdEn || st.wrEn) == (st.nBytes != 4'd0));

  // Selector reads never act (R10)
  a_r10_sel_read_idle: assert property (@(posedge clk) disable iff (rst)
    (reqValid && !reqWrite && reqAddr == OFS_SEL) |-> !(st.selWr || st.rdEn || st.wrEn));

endmodule

// File: rtl/cfg_blob_dp.sv
module cfg_blob_dp
  import cfg_blob_pkg::*;
#(
  parameter int          SCR_BYTES = 8,
  parameter logic [31:0] SIG       = 32'h4346_4750,
  parameter logic [31:0] REV       = 32'h0000_0000
) (
  input  logic         clk,
  input  logic         rst,
  input  ctrlStrobes_t st,
  input  logic [63:0]  reqWdata,
  output logic         rspValid,
  output logic [63:0]  rspData
);

  localparam int MAX_LEN = (SCR_BYTES > 4) ? SCR_BYTES : 4;
  localparam int CUR_W   = $clog2(MAX_LEN + 1);
  localparam int PW      = CUR_W + 4;

  logic [15:0]       key;
  logic [CUR_W-1:0]  cursor;
  logic [7:0]        scratch [SCR_BYTES];
  logic [PW-1:0]     curLen;
  logic [PW-1:0]     cursorSum;
  logic [PW-1:0]     cursorNext;
  logic              writable;
  logic              moves;
  logic [63:0]       rdWord;

  always_comb begin
    unique case (key)
      KEY_SIG: curLen = PW'(4);
      KEY_REV: curLen = PW'(4);
      KEY_SCR: curLen = PW'(SCR_BYTES);
      default: curLen = '0;
    endcase
  end

  assign writable   = (key == KEY_SCR);
  assign moves      = st.rdEn || (st.wrEn && writable);
  assign cursorSum  = PW'(cursor) + PW'(st.nBytes);
  assign cursorNext = (cursorSum > curLen) ? curLen : cursorSum;

  // Stream bytes gathered into lanes, earliest byte in lane 0
  always_comb begin
    rdWord = '0;
    for (int i = 0; i < 8; i++) begin
      logic [PW-1:0] pos;
      logic [7:0]    b;
      pos = PW'(cursor) + PW'(i);
      b   = 8'h00;
      if (PW'(i) < PW'(st.nBytes) && pos < curLen) begin
        unique case (key)
          KEY_SIG: b = 8'(SIG >> {~pos[1:0], 3'b000});
          KEY_REV: b = 8'(REV >> {pos[1:0], 3'b000});
          KEY_SCR: begin
            for (int j = 0; j < SCR_BYTES; j++)
              if (pos == PW'(j)) b = scratch[j];
          end
          default: b = 8'h00;
        endcase
      end
      rdWord[8*i +: 8] = b;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      key    <= KEY_SIG;
      cursor <= '0;
    end else if (st.selWr) begin
      if (st.selHiEn) key[15:8] <= reqWdata[7:0];
      if (st.selLoEn) key[7:0]  <= reqWdata[15:8];
      cursor <= '0;
    end else if (moves) begin
      cursor <= CUR_W'(cursorNext);
    end
  end

  for (genvar j = 0; j < SCR_BYTES; j++) begin : g_scr
    always_ff @(posedge clk) begin
      if (rst) begin
        scratch[j] <= 8'h00;
      end else if (st.wrEn && writable) begin
        for (int i = 0; i < 8; i++) begin
          if (PW'(i) < PW'(st.nBytes) && PW'(cursor) + PW'(i) == PW'(j))
            scratch[j] <= reqWdata[8*i +: 8];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= st.accept;
      rspData  <= st.rdEn ? rdWord : 64'h0;
    end
  end

  a_r2_rsp_follows: assert property (@(posedge clk) disable iff (rst)
    st.accept |=> rspValid);

  a_r2_rsp_only_after_req: assert property (@(posedge clk) disable iff (rst)
    !st.accept |=> !rspValid);

  a_r3_sel_rewinds: assert property (@(posedge clk) disable iff (rst)
    st.selWr |=> cursor == '0);

  a_r7_cursor_bound: assert property (@(posedge clk) disable iff (rst)
    PW'(cursor) <= curLen);

  a_r9_ro_write_still: assert property (@(posedge clk) disable iff (rst)
    (st.wrEn && !writable) |=> $stable(cursor) && $stable(key));

  a_r10_idle_still: assert property (@(posedge clk) disable iff (rst)
    !(st.selWr || st.rdEn || st.wrEn) |=> $stable(cursor) && $stable(key));

  a_r11_nonread_zero: assert property (@(posedge clk) disable iff (rst)
    !st.rdEn |=> rspData == 64'h0);

endmodule

// File: rtl/cfg_blob_port.sv
module cfg_blob_port
  import cfg_blob_pkg::*;
#(
  parameter int          SCR_BYTES = 8,
  parameter logic [31:0] SIG       = 32'h4346_4750,
  parameter logic [31:0] REV       = 32'h0000_0000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic        reqWrite,
  input  logic [3:0]  reqAddr,
  input  logic [7:0]  reqStrb,
  input  logic [63:0] reqWdata,
  output logic        rspValid,
  output logic [63:0] rspData
);

  ctrlStrobes_t st;

  cfg_blob_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .reqStrb  (reqStrb),
    .reqReady (reqReady),
    .st       (st)
  );

  cfg_blob_dp #(
    .SCR_BYTES (SCR_BYTES),
    .SIG       (SIG),
    .REV       (REV)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .st       (st),
    .reqWdata (reqWdata),
    .rspValid (rspValid),
    .rspData  (rspData)
  );

endmodule

// File: tb/sim_cfg_blob_port.sv
`timescale 1ns/1ps
module sim_cfg_blob_port;

  localparam int SCR = 12;

  logic        clk = 1'b0;
  logic        rst;
  logic        reqValid;
  logic        reqReady;
  logic        reqWrite;
  logic [3:0]  reqAddr;
  logic [7:0]  reqStrb;
  logic [63:0] reqWdata;
  logic        rspValid;
  logic [63:0] rspData;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  // Reference model state
  logic [15:0] mKey;
  int          mCur;
  logic [7:0]  mScr [SCR];

  always #2 clk = ~clk;

  cfg_blob_port #(.SCR_BYTES(SCR)) u0 (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqStrb(reqStrb),
    .reqWdata(reqWdata), .rspValid(rspValid), .rspData(rspData)
  );

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic int mLen(input logic [15:0] k);
    case (k)
      16'h0000: return 4;
      16'h0001: return 4;
      16'h0002: return SCR;
      default:  return 0;
    endcase
  endfunction

  function automatic logic [7:0] mByte(input logic [15:0] k, input int p);
    logic [31:0] sig;
    sig = 32'h4346_4750;
    if (p >= mLen(k)) return 8'h00;
    case (k)
      16'h0000: return sig[8*(3-p) +: 8];
      16'h0002: return mScr[p];
      default:  return 8'h00;
    endcase
  endfunction

  function automatic int strbWidth(input logic [7:0] s);
    case (s)
      8'h01: return 1;
      8'h03: return 2;
      8'h0F: return 4;
      8'hFF: return 8;
      default: return 0;
    endcase
  endfunction

  // Expected result of a legal data read; advances the model cursor
  function automatic logic [63:0] mRead(input int n);
    logic [63:0] w;
    w = '0;
    for (int i = 0; i < n; i++) w[8*i +: 8] = mByte(mKey, mCur + i);
    mCur = (mCur + n > mLen(mKey)) ? mLen(mKey) : mCur + n;
    return w;
  endfunction

  function automatic void mWrite(input int n, input logic [63:0] d);
    if (mKey != 16'h0002) return;
    for (int i = 0; i < n; i++)
      if (mCur + i < SCR) mScr[mCur + i] = d[8*i +: 8];
    mCur = (mCur + n > SCR) ? SCR : mCur + n;
  endfunction

  // One access; returns response data, checks response timing
  task automatic access(input logic wr, input logic [3:0] a, input logic [7:0] s,
                        input logic [63:0] d, output logic [63:0] r);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqStrb = s; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0;
    check("R2 rspValid after request", {63'b0, rspValid}, 64'h1);
    r = rspData;
  endtask

  task automatic selKey(input logic [15:0] k);
    logic [63:0] r;
    access(1'b1, 4'h8, 8'h03, {48'h0, k[7:0], k[15:8]}, r);
    check("R11 selector write response", r, 64'h0);
    mKey = k; mCur = 0;
  endtask

  task automatic rd(input logic [7:0] s, input string tag);
    logic [63:0] r, e;
    access(1'b0, 4'h0, s, 64'h0, r);
    e = mRead(strbWidth(s));
    check(tag, r, e);
  endtask

  task automatic wr(input logic [7:0] s, input logic [63:0] d);
    logic [63:0] r;
    access(1'b1, 4'h0, s, d, r);
    check("R11 data write response", r, 64'h0);
    mWrite(strbWidth(s), d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++; nChecks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    logic [63:0] r;
    void'($urandom(32'd1234));
    reqValid = 0; reqWrite = 0; reqAddr = 0; reqStrb = 0; reqWdata = 0;
    rst = 1'b1;
    mKey = 16'h0000; mCur = 0;
    for (int j = 0; j < SCR; j++) mScr[j] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state, R2 ready
    check("R1 rspValid low after reset", {63'b0, rspValid}, 64'h0);
    check("R2 reqReady high", {63'b0, reqReady}, 64'h1);
    // R1/R5: signature selected by reset
    access(1'b0, 4'h0, 8'h0F, 64'h0, r);
    check("R1 R5 signature after reset", r, 64'h0000_0000_5047_4643);
    mCur = 4;
    @(negedge clk);
    check("R2 rspValid single cycle", {63'b0, rspValid}, 64'h0);
    rd(8'h01, "R7 past end of signature");

    // R5/R4 byte stream and 16-bit packing
    selKey(16'h0000);
    for (int i = 0; i < 4; i++) rd(8'h01, "R5 signature byte");
    selKey(16'h0000);
    rd(8'h03, "R4 16-bit read lanes");
    rd(8'h03, "R4 16-bit read continues");
    selKey(16'h0000);
    rd(8'hFF, "R4 R7 64-bit read straddles end");

    // R6 revision, R7 unknown key
    selKey(16'h0001);
    rd(8'h0F, "R6 revision value");
    selKey(16'h1234);
    rd(8'hFF, "R7 unknown key reads zero");

    // R1 scratch zero after reset, R8 writes
    selKey(16'h0002);
    rd(8'hFF, "R1 scratch zero after reset");
    selKey(16'h0002);
    wr(8'hFF, 64'h8877_6655_4433_2211);
    wr(8'h0F, 64'h0000_0000_DDCC_BBAA);
    wr(8'h0F, 64'h0000_0000_1111_1111);
    selKey(16'h0002);
    rd(8'hFF, "R8 scratch first word");
    rd(8'hFF, "R8 R7 scratch tail");

    // R3 big-endian selector, per-byte strobes
    access(1'b1, 4'h8, 8'h01, 64'h02, r);
    mKey = 16'h0202; mCur = 0;
    rd(8'h01, "R3 upper byte written alone");
    access(1'b1, 4'h8, 8'h01, 64'h00, r);
    mKey = 16'h0002; mCur = 0;
    rd(8'h01, "R3 key back to scratch");

    // R9 read-only writes ignored
    selKey(16'h0000);
    wr(8'h0F, 64'hFFFF_FFFF);
    rd(8'h0F, "R9 signature unchanged, cursor unmoved");
    selKey(16'h0001);
    wr(8'hFF, 64'h1);
    rd(8'h0F, "R9 revision unchanged");

    // R10 illegal accesses
    selKey(16'h0002);
    rd(8'h01, "R10 setup");
    access(1'b0, 4'h8, 8'h03, 64'h0, r);
    check("R10 selector read zero", r, 64'h0);
    access(1'b0, 4'h0, 8'h07, 64'h0, r);
    check("R10 bad strobe read zero", r, 64'h0);
    access(1'b0, 4'h4, 8'hFF, 64'h0, r);
    check("R10 offset 4 read zero", r, 64'h0);
    access(1'b1, 4'h4, 8'hFF, 64'hAAAA, r);
    access(1'b1, 4'h0, 8'h07, 64'h00EE_EEEE, r);
    access(1'b1, 4'h8, 8'h04, 64'h00FF_FFFF, r);
    access(1'b1, 4'h8, 8'h07, 64'h00FF_FFFF, r);
    rd(8'h01, "R10 cursor and key unchanged");
    rd(8'h01, "R10 scratch unchanged");

    // Constrained random mix
    for (int n = 0; n < 400; n++) begin
      int op;
      logic [7:0] s;
      logic [15:0] k;
      logic [63:0] d;
      op = $urandom % 10;
      case ($urandom % 4)
        0: s = 8'h01; 1: s = 8'h03; 2: s = 8'h0F; default: s = 8'hFF;
      endcase
      d = {$urandom, $urandom};
      if (op < 2) begin
        k = ($urandom % 5 == 0) ? 16'($urandom) : 16'($urandom % 3);
        selKey(k);
      end else if (op < 6) begin
        rd(s, "R4 R7 R8 random read");
      end else if (op < 9) begin
        wr(s, d);
      end else begin
        access($urandom % 2 == 1, 4'($urandom % 7 + 1), s, d, r);
        check("R10 random illegal access zero", r, 64'h0);
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule